// File: doc/BRIEF.md
# Boot Sequencing Controller

This block takes over the start-up flow once the reset generator reports that it has gone idle and the configuration records and trims are installed. It first checks whether a test-port request is pending and, if so, parks in a hold state without starting any code. Otherwise it reads a bypass status bit loaded from a configuration record. With the bit clear it launches the boot-assist code from a fixed start address. With the bit set it reads a boot header from flash, one field per handshake. The header fields are, in order: ID, boot CPU selection, start address, CPU reset vector. The controller checks the ID, then takes the CPU selection and the start address.

Releasing a core is done in a fixed order. The start address is placed on the core vector output, the core clock is then enabled, and only after that is the core reset deasserted, with a one-cycle done pulse. A reset request from the reset generator aborts everything at any time and returns the controller to waiting for idle.

Top module: `boot_seq_ctrl`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises: state_o is 0, core_clk_en_o is 0, core_rst_no is 0, boot_done_o is 0, hdr_req_o is 0 and core_vec_o is 0.
- R2: In the wait state (state_o = 0) the controller stays put until rgm_idle_i and cfg_done_i are both high at the same clock edge. After that edge state_o is 1 (test check).
- R3: In the test check, a high test_req_i moves state_o to 5 (test hold). That state is kept until a reset request arrives, and the core stays in reset with its clock gated.
- R4: In the bypass check (state_o = 2), a low bypass_en_i moves state_o to 4 (launch) with core_vec_o = BAF_ADDR and core_sel_o = BAF_CPU.
- R5: A high bypass_en_i moves state_o to 3 (header read). hdr_req_o is then high and hdr_idx_o walks through 0 (ID), 1 (CPU select) and 2 (start address), moving on only on a cycle where hdr_ack_i is high. Index 3 is never requested.
- R6: If the word acknowledged at index 0 differs from HDR_ID, state_o becomes 6 (error). That state is kept until a reset request, and the core stays in reset with its clock gated.
- R7: With a valid ID, the ack of index 2 moves state_o to 4. core_sel_o then carries bits [CPU_W-1:0] of the word acknowledged at index 1, and core_vec_o carries the word acknowledged at index 2.
- R8: core_vec_o is loaded on entry to launch and is stable for VEC_SETUP cycles before core_clk_en_o rises.
- R9: core_clk_en_o is high for CLK_SETUP cycles before core_rst_no rises.
- R10: boot_done_o is high for exactly the one cycle in which core_rst_no first rises.
- R11: rgm_reset_req_i high at an edge, in any state, gives state_o = 0 after that edge, with core_clk_en_o = 0, core_rst_no = 0 and core_vec_o = 0.
- R12: state_o encodes wait 0, test check 1, bypass check 2, header read 3, launch 4, test hold 5, error 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rgm_idle_i | input | 1 | Reset generator has reached idle |
| rgm_reset_req_i | input | 1 | New reset event from the reset generator |
| cfg_done_i | input | 1 | Configuration records and trims installed |
| test_req_i | input | 1 | Pending test-port request |
| bypass_en_i | input | 1 | Boot-assist bypass status bit |
| hdr_req_o | output | 1 | Header word request |
| hdr_idx_o | output | 2 | Header field index requested |
| hdr_ack_i | input | 1 | Header word valid on hdr_data_i |
| hdr_data_i | input | ADDR_W | Header word |
| core_sel_o | output | CPU_W | Selected boot CPU |
| core_vec_o | output | ADDR_W | Core reset vector |
| core_clk_en_o | output | 1 | Core clock enable |
| core_rst_no | output | 1 | Core reset, active low |
| boot_done_o | output | 1 | One-cycle pulse at core release |
| state_o | output | 3 | Controller state code |

## Verification
Each boot attempt takes one of four paths: test request pending, bypass clear, bypass set with a valid header, or bypass set with a corrupt ID. The first four attempts walk these paths in turn, and random attempts follow. Comparing the final state separates the hold, error and launch outcomes. Comparing the vector and CPU select separates the fixed boot-assist address from header-supplied values. Random header acknowledge stalls show whether the field index advances only on an accepted word. Random idle, config-done and reset-request pulses, including some that land inside the header read and the release ramp, check that the controller abandons the attempt and re-gates the core.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT      = 3'd0,
    ST_TEST_CHK  = 3'd1,
    ST_BYP_CHK   = 3'd2,
    ST_HDR_RD    = 3'd3,
    ST_LAUNCH    = 3'd4,
    ST_TEST_HOLD = 3'd5,
    ST_ERROR     = 3'd6
  } boot_state_e;

  // header field order: id, cpu select, start address, reset vector
  localparam int unsigned HDR_IDX_W = 2;
  localparam logic [HDR_IDX_W-1:0] HDR_IDX_ID    = 2'd0;
  localparam logic [HDR_IDX_W-1:0] HDR_IDX_CPU   = 2'd1;
  localparam logic [HDR_IDX_W-1:0] HDR_IDX_START = 2'd2;
endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rgm_idle_i,
  input  logic        rgm_reset_req_i,
  input  logic        cfg_done_i,
  input  logic        test_req_i,
  input  logic        bypass_en_i,
  input  logic        hdr_id_bad_i,
  input  logic        hdr_last_i,
  output boot_state_e state_o,
  output logic        load_baf_o,
  output logic        load_hdr_o
);
  boot_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rgm_reset_req_i) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT:     if (rgm_idle_i && cfg_done_i) state_d = ST_TEST_CHK;
        ST_TEST_CHK: state_d = test_req_i ? ST_TEST_HOLD : ST_BYP_CHK;
        ST_BYP_CHK:  state_d = bypass_en_i ? ST_HDR_RD : ST_LAUNCH;
        ST_HDR_RD: begin
          if (hdr_id_bad_i)    state_d = ST_ERROR;
          else if (hdr_last_i) state_d = ST_LAUNCH;
        end
        default: state_d = state_q;
      endcase
    end
  end

  assign load_baf_o = (state_q == ST_BYP_CHK) && !bypass_en_i && !rgm_reset_req_i;
  assign load_hdr_o = (state_q == ST_HDR_RD) && hdr_last_i && !hdr_id_bad_i && !rgm_reset_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_hold_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TEST_HOLD && !rgm_reset_req_i) |=> state_q == ST_TEST_HOLD);
  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERROR && !rgm_reset_req_i) |=> state_q == ST_ERROR);
  assert_wait_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !(rgm_idle_i && cfg_done_i)) |=> state_q == ST_WAIT);
endmodule

// File: rtl/boot_hdr_reader.sv
module boot_hdr_reader
  import boot_seq_pkg::*;
#(
  parameter int unsigned        ADDR_W = 32,
  parameter int unsigned        CPU_W  = 2,
  parameter logic [ADDR_W-1:0]  HDR_ID = 32'h5AA5_0B00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  logic                 ack_i,
  input  logic [ADDR_W-1:0]    data_i,
  output logic [HDR_IDX_W-1:0] idx_o,
  output logic                 id_bad_o,
  output logic                 last_o,
  output logic [CPU_W-1:0]     sel_o
);
  logic [HDR_IDX_W-1:0] idx_q;
  logic [CPU_W-1:0]     sel_q;
  logic                 take;

  assign take     = active_i && ack_i;
  assign id_bad_o = take && (idx_q == HDR_IDX_ID) && (data_i != HDR_ID);
  assign last_o   = take && (idx_q == HDR_IDX_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sel_q <= '0;
    end else if (!active_i) begin
      idx_q <= '0;
    end else if (take) begin
      if (idx_q == HDR_IDX_CPU) sel_q <= data_i[CPU_W-1:0];
      idx_q <= (last_o || id_bad_o) ? '0 : idx_q + 1'b1;
    end
  end

  assign idx_o = idx_q;
  assign sel_o = sel_q;

  assert_idx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !ack_i) |=> ($stable(idx_q) || !active_i));
  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && idx_q != HDR_IDX_START && !id_bad_o) |=> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/boot_core_release.sv
module boot_core_release #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CPU_W     = 2,
  parameter int unsigned VEC_SETUP = 1,
  parameter int unsigned CLK_SETUP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] vec_d_i,
  input  logic [CPU_W-1:0]  sel_d_i,
  output logic [ADDR_W-1:0] vec_o,
  output logic [CPU_W-1:0]  sel_o,
  output logic              clk_en_o,
  output logic              rst_no,
  output logic              done_o
);
  localparam int unsigned REL_AT = VEC_SETUP + CLK_SETUP;
  localparam int unsigned CNT_W  = $clog2(REL_AT + 2);
  localparam logic [CNT_W-1:0] CLK_CNT = CNT_W'(VEC_SETUP);
  localparam logic [CNT_W-1:0] REL_CNT = CNT_W'(REL_AT);
  localparam logic [CNT_W-1:0] SAT_CNT = CNT_W'(REL_AT + 1);

  logic [ADDR_W-1:0] vec_q;
  logic [CPU_W-1:0]  sel_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      sel_q <= '0;
    end else if (clr_i) begin
      vec_q <= '0;
      sel_q <= '0;
    end else if (load_i) begin
      vec_q <= vec_d_i;
      sel_q <= sel_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!launch_i || clr_i)  cnt_q <= '0;
    else if (cnt_q != SAT_CNT)    cnt_q <= cnt_q + 1'b1;
  end

  assign clk_en_o = launch_i && (cnt_q >= CLK_CNT);
  assign rst_no   = launch_i && (cnt_q >= REL_CNT);
  assign done_o   = launch_i && (cnt_q == REL_CNT);
  assign vec_o    = vec_q;
  assign sel_o    = sel_q;

  assert_vec_before_clk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> $stable(vec_o));
  assert_clk_before_rst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(clk_en_o));
  assert_rst_needs_clk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no |-> clk_en_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        CPU_W     = 2,
  parameter logic [ADDR_W-1:0]  HDR_ID    = 32'h5AA5_0B00,
  parameter logic [ADDR_W-1:0]  BAF_ADDR  = 32'h0040_0000,
  parameter logic [CPU_W-1:0]   BAF_CPU   = '0,
  parameter int unsigned        VEC_SETUP = 1,
  parameter int unsigned        CLK_SETUP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rgm_idle_i,
  input  logic              rgm_reset_req_i,
  input  logic              cfg_done_i,
  input  logic              test_req_i,
  input  logic              bypass_en_i,
  output logic              hdr_req_o,
  output logic [1:0]        hdr_idx_o,
  input  logic              hdr_ack_i,
  input  logic [ADDR_W-1:0] hdr_data_i,
  output logic [CPU_W-1:0]  core_sel_o,
  output logic [ADDR_W-1:0] core_vec_o,
  output logic              core_clk_en_o,
  output logic              core_rst_no,
  output logic              boot_done_o,
  output logic [2:0]        state_o
);
  boot_state_e           state;
  logic                  load_baf, load_hdr, id_bad, hdr_last;
  logic [HDR_IDX_W-1:0]  idx;
  logic [CPU_W-1:0]      hdr_sel;

  boot_seq_fsm i_fsm (
    .clk_i, .rst_ni, .rgm_idle_i, .rgm_reset_req_i, .cfg_done_i,
    .test_req_i, .bypass_en_i,
    .hdr_id_bad_i (id_bad),
    .hdr_last_i   (hdr_last),
    .state_o      (state),
    .load_baf_o   (load_baf),
    .load_hdr_o   (load_hdr)
  );

  boot_hdr_reader #(.ADDR_W(ADDR_W), .CPU_W(CPU_W), .HDR_ID(HDR_ID)) i_hdr (
    .clk_i, .rst_ni,
    .active_i (state == ST_HDR_RD),
    .ack_i    (hdr_ack_i),
    .data_i   (hdr_data_i),
    .idx_o    (idx),
    .id_bad_o (id_bad),
    .last_o   (hdr_last),
    .sel_o    (hdr_sel)
  );

  boot_core_release #(.ADDR_W(ADDR_W), .CPU_W(CPU_W),
                      .VEC_SETUP(VEC_SETUP), .CLK_SETUP(CLK_SETUP)) i_rel (
    .clk_i, .rst_ni,
    .clr_i    (rgm_reset_req_i),
    .load_i   (load_baf || load_hdr),
    .launch_i (state == ST_LAUNCH),
    .vec_d_i  (load_baf ? BAF_ADDR : hdr_data_i),
    .sel_d_i  (load_baf ? BAF_CPU : hdr_sel),
    .vec_o    (core_vec_o),
    .sel_o    (core_sel_o),
    .clk_en_o (core_clk_en_o),
    .rst_no   (core_rst_no),
    .done_o   (boot_done_o)
  );

  assign hdr_req_o = (state == ST_HDR_RD);
  assign hdr_idx_o = idx;
  assign state_o   = state;

  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rgm_reset_req_i |=> (state_o == 3'd0 && !core_clk_en_o && !core_rst_no));
  assert_no_release_off_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd4) |-> (!core_clk_en_o && !core_rst_no));
endmodule

// File: tb/test_boot_seq_ctrl.sv
module test_boot_seq_ctrl;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CPU_W  = 2;
  localparam logic [31:0] HDR_ID   = 32'h5AA5_0B00;
  localparam logic [31:0] BAF_ADDR = 32'h0040_0000;
  localparam int CYCLES = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rgm_idle = 0, reset_req = 0, cfg_done = 0, test_req = 0, bypass = 0, hdr_ack = 0;
  logic [31:0] hdr_data = '0;
  logic hdr_req, clk_en, core_rst_n, done;
  logic [1:0] hdr_idx;
  logic [CPU_W-1:0] sel;
  logic [31:0] vec;
  logic [2:0] state;

  always #2 clk = ~clk;

  boot_seq_ctrl i_boot_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rgm_idle_i(rgm_idle), .rgm_reset_req_i(reset_req),
    .cfg_done_i(cfg_done), .test_req_i(test_req), .bypass_en_i(bypass),
    .hdr_req_o(hdr_req), .hdr_idx_o(hdr_idx), .hdr_ack_i(hdr_ack), .hdr_data_i(hdr_data),
    .core_sel_o(sel), .core_vec_o(vec), .core_clk_en_o(clk_en), .core_rst_no(core_rst_n),
    .boot_done_o(done), .state_o(state)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  int m_st = 0, m_cnt = 0, m_idx = 0;
  logic [31:0] m_vec = '0;
  logic [CPU_W-1:0] m_sel = '0, m_hsel = '0;
  bit last_abort = 0;
  int term_cnt = 0, scen = 0;
  bit sc_test, sc_byp, sc_valid;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string st_req(int s, bit abort);
    if (abort) return "R11";
    case (s)
      0: return "R2";
      3: return "R5";
      4: return "R4";
      5: return "R3";
      6: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic model_step();
    last_abort = reset_req;
    if (reset_req) begin
      m_st = 0; m_cnt = 0; m_idx = 0; m_vec = '0; m_sel = '0;
      return;
    end
    case (m_st)
      0: if (rgm_idle && cfg_done) m_st = 1;
      1: m_st = test_req ? 5 : 2;
      2: if (bypass) begin m_st = 3; m_idx = 0; end
         else begin m_st = 4; m_cnt = 0; m_vec = BAF_ADDR; m_sel = '0; end
      3: if (hdr_ack) begin
           if (m_idx == 0 && hdr_data != HDR_ID) m_st = 6;
           else if (m_idx == 1) begin m_hsel = hdr_data[CPU_W-1:0]; m_idx = 2; end
           else if (m_idx == 2) begin m_st = 4; m_cnt = 0; m_vec = hdr_data; m_sel = m_hsel; end
           else m_idx = m_idx + 1;
         end
      4: if (m_cnt < 3) m_cnt++;
      default: ;
    endcase
  endtask

  task automatic compare_all();
    bit exp_clk, exp_rel, exp_done;
    exp_clk  = (m_st == 4) && (m_cnt >= 1);
    exp_rel  = (m_st == 4) && (m_cnt >= 2);
    exp_done = (m_st == 4) && (m_cnt == 2);
    chk(st_req(m_st, last_abort), "state", {29'd0, state}, m_st);
    chk("R8", "clk_en", {31'd0, clk_en}, {31'd0, exp_clk});
    chk("R9", "core_rst_n", {31'd0, core_rst_n}, {31'd0, exp_rel});
    chk("R10", "done", {31'd0, done}, {31'd0, exp_done});
    chk("R4/R7", "vec", vec, m_vec);
    chk("R7", "sel", {30'd0, sel}, {30'd0, m_sel});
    chk("R5", "hdr_req", {31'd0, hdr_req}, {31'd0, m_st == 3});
    if (m_st == 3) chk("R5", "hdr_idx", {30'd0, hdr_idx}, m_idx);
  endtask

  task automatic new_scenario();
    case (scen)
      0: begin sc_test = 0; sc_byp = 0; sc_valid = 1; end
      1: begin sc_test = 1; sc_byp = 0; sc_valid = 1; end
      2: begin sc_test = 0; sc_byp = 1; sc_valid = 1; end
      3: begin sc_test = 0; sc_byp = 1; sc_valid = 0; end
      default: begin
        sc_test  = ($urandom % 4) == 0;
        sc_byp   = ($urandom % 2) == 0;
        sc_valid = ($urandom % 4) != 0;
      end
    endcase
    scen++;
  endtask

  task automatic drive();
    if (m_st == 5 || m_st == 6 || (m_st == 4 && m_cnt == 3)) term_cnt++;
    else term_cnt = 0;
    if (term_cnt >= 4) begin
      reset_req = 1; term_cnt = 0; new_scenario();
    end else begin
      reset_req = (scen > 4) && (($urandom % 80) == 0);
    end
    rgm_idle = ($urandom % 3) != 0;
    cfg_done = ($urandom % 4) != 0;
    test_req = sc_test;
    bypass   = sc_byp;
    hdr_ack  = (m_st == 3) && (($urandom % 3) != 0);
    if (m_st == 3 && m_idx == 0) hdr_data = sc_valid ? HDR_ID : (HDR_ID ^ (32'd1 << ($urandom % 32)));
    else hdr_data = $urandom;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hB007));
    new_scenario();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "state", {29'd0, state}, 0);
    chk("R1", "clk_en", {31'd0, clk_en}, 0);
    chk("R1", "core_rst_n", {31'd0, core_rst_n}, 0);
    chk("R1", "done", {31'd0, done}, 0);
    chk("R1", "hdr_req", {31'd0, hdr_req}, 0);
    chk("R1", "vec", vec, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "state after release", {29'd0, state}, 0);
    for (int c = 0; c < CYCLES; c++) begin
      drive();
      @(negedge clk);
      model_step();
      compare_all();
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule